// File: doc/BRIEF.md
# Wide Doorbell Write Collector

This block sits on the host write path of a queue-based I/O device. It lets a host whose bus carries only 32 or 64 bits per write update a 128-bit write-only doorbell register without a lock on the host side. Dword or qword writes aimed at a doorbell are gathered lane by lane in a collector. A write that carries the top dword (bytes 12..15 of the register) always releases the full 128-bit word to the queue logic behind the block. Any lower lane that was not gathered goes out as zero. The doorbell contents are defined so that zeros in those lanes are harmless.

The address space is split into pages of a fixed power-of-two size, one page per queue. The page index is the address divided by the page size, and the remainder is the register offset. Each page holds two doorbells, a timer-command register and other plain 32-bit registers. Plain registers bypass the collector and are forwarded as single dword writes. A dword write to the timer-command register of page 0 also throws away whatever the collector holds. Misaligned accesses are dropped and flagged. The collector is never readable.

Top module: `wide_doorbell_collector`

## Requirements
- R1: After reset, `commit_valid`, `plain_valid` and `err_o` are low and the collector is empty, so a lone top-dword write commits zeros in bits 95:0.
- R2: Four dword writes at offsets 0, 4, 8 and 12 of a doorbell produce one commit in the cycle after the offset-12 write. The dword written at offset 4n appears at bits 32n+31:32n.
- R3: Two 64-bit writes at offsets 0 and 8 produce one commit in the cycle after the offset-8 write. For each qword, `wr_data[31:0]` fills the lower dword and `wr_data[63:32]` the upper one.
- R4: A dword write to the top dword alone (page offset 0x83c or 0xa1c) commits with bits 95:0 equal to zero.
- R5: At commit, every lower lane that was neither gathered nor written by the committing access is zero. Gathered lanes keep their values.
- R6: `commit_valid` is a pulse of one cycle. It carries the page index and `commit_reg` (0 for the doorbell at 0x830, 1 for the one at 0xa10). After a commit the collector is empty.
- R7: The page index is `wr_addr` divided by the page size and the offset is the remainder. The page size is 0x2000 with `BIG_PAGES`=0 and 0x10000 with `BIG_PAGES`=1.
- R8: A dword write to offset 0x420 in page 0 empties the collector. The same write in any other page leaves the collector untouched.
- R9: A doorbell write to a different doorbell or a different page than the one being gathered discards the earlier lanes before storing the new ones.
- R10: An aligned dword write to any offset outside both doorbells appears in the next cycle on `plain_valid`, `plain_page`, `plain_offset` and `plain_data` (= `wr_data[31:0]`). Apart from R8, it leaves the collector unchanged.
- R11: The following accesses are ignored: a dword write with `wr_addr[1:0]`≠0, a qword write with `wr_addr[2:0]`≠0, and a qword write outside a doorbell. Each raises `err_o` for one cycle in the next cycle, with no commit, no plain write and no change to the collector.
- R12: A timer-command write is also forwarded as a plain write, in every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | host write strobe, one write per cycle |
| wr_dw64 | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_addr | input | ADDR_W | byte address of the write |
| wr_data | input | 64 | write data; bits 31:0 only for 32-bit writes |
| commit_valid | output | 1 | one-cycle doorbell commit pulse |
| commit_reg | output | 1 | doorbell identifier: 0 at 0x830, 1 at 0xa10 |
| commit_page | output | PG_W | page (queue) index of the commit |
| commit_data | output | 128 | committed doorbell value |
| plain_valid | output | 1 | one-cycle plain-register write pulse |
| plain_page | output | PG_W | page index of the plain write |
| plain_offset | output | PG_SHIFT | page offset of the plain write |
| plain_data | output | 32 | plain write data |
| err_o | output | 1 | one-cycle pulse for an ignored access |

## Verification
The bench builds two copies of the block with `ADDR_W`=24 and feeds both the same writes. One copy uses `BIG_PAGES`=0, which gives 11 page bits. The other uses `BIG_PAGES`=1, which gives 8 page bits. A single address such as 0x10830 therefore falls in page 8 of the first copy and in page 1 of the second, which checks the page split for both page sizes. The small page size puts pages 0, 1 and 2 inside a short address range, so switching pages, invalidation in page 0 compared with page 1, and each doorbell can all be reached with a few writes.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 32;
  localparam int WIDE_W = LANES * LANE_W;

  typedef enum logic {DB_LOW = 1'b0, DB_HIGH = 1'b1} db_id_e;

  // page index: address divided by a power-of-two page size
  function automatic logic [31:0] page_of(input logic [31:0] a, input int shift);
    return a >> shift;
  endfunction

  // offset inside the page
  function automatic logic [31:0] off_of(input logic [31:0] a, input int shift);
    return a & ((32'd1 << shift) - 32'd1);
  endfunction

  // natural alignment for dword and qword accesses
  function automatic logic is_aligned(input logic dw64, input logic [2:0] lo);
    return dw64 ? (lo == 3'd0) : (lo[1:0] == 2'd0);
  endfunction

  // lanes covered by one access
  function automatic logic [LANES-1:0] lanes_hit(input logic dw64, input logic [1:0] lane);
    return dw64 ? (LANES'(2'b11) << lane) : (LANES'(1'b1) << lane);
  endfunction
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
  import dbc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PG_SHIFT = 13,
  parameter int PG_W     = ADDR_W - PG_SHIFT,
  parameter logic [31:0] DB0_OFF = 32'h0830,
  parameter logic [31:0] DB1_OFF = 32'h0a10,
  parameter logic [31:0] TMR_OFF = 32'h0420
) (
  input  logic              fire,
  input  logic              dw64,
  input  logic [ADDR_W-1:0] addr,
  output logic [PG_W-1:0]   page,
  output logic [PG_SHIFT-1:0] off,
  output logic              hit_wide,
  output db_id_e            wide_id,
  output logic [LANES-1:0]  lane_mask,
  output logic              hit_plain,
  output logic              hit_inval,
  output logic              hit_bad
);
  logic [31:0] a32;
  logic [31:0] off32;
  logic        in_a, in_b, ok;

  assign a32   = 32'(addr);
  assign off32 = off_of(a32, PG_SHIFT);
  assign page  = PG_W'(page_of(a32, PG_SHIFT));
  assign off   = PG_SHIFT'(off32);

  assign in_a = ((off32 & ~32'hF) == DB0_OFF);
  assign in_b = ((off32 & ~32'hF) == DB1_OFF);
  assign ok   = is_aligned(dw64, a32[2:0]);

  assign hit_wide  = fire && ok && (in_a || in_b);
  assign wide_id   = in_b ? DB_HIGH : DB_LOW;
  assign lane_mask = lanes_hit(dw64, off32[3:2]);
  assign hit_plain = fire && ok && !dw64 && !(in_a || in_b);
  assign hit_inval = hit_plain && (off32 == TMR_OFF) && (page == '0);
  assign hit_bad   = fire && !hit_wide && !hit_plain;
endmodule

// File: rtl/dbc_collector.sv
module dbc_collector
  import dbc_pkg::*;
#(
  parameter int PG_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              wr_dw64,
  input  db_id_e            wr_id,
  input  logic [PG_W-1:0]   wr_page,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [63:0]       wr_data,
  input  logic              inval,
  output logic              commit_v,
  output db_id_e            commit_id,
  output logic [PG_W-1:0]   commit_page,
  output logic [WIDE_W-1:0] commit_data,
  output logic [LANES-1:0]  held_vld
);
  logic [LANES-1:0]  vld_q;
  logic [LANE_W-1:0] dw_q [LANES];
  logic [LANE_W-1:0] merged [LANES];
  logic [WIDE_W-1:0] merged_flat;
  db_id_e            id_q;
  logic [PG_W-1:0]   page_q;
  logic              same_tag, fire_top, gather;
  logic [LANES-1:0]  keep;

  assign same_tag = (|vld_q) && (id_q == wr_id) && (page_q == wr_page);
  assign keep     = same_tag ? vld_q : '0;
  assign fire_top = wr_hit && wr_mask[LANES-1];
  assign gather   = wr_hit && !wr_mask[LANES-1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i] = wr_mask[i] ? (((i % 2) == 1 && wr_dw64) ? wr_data[63:32] : wr_data[31:0])
                                  : (keep[i] ? dw_q[i] : '0);
    assign merged_flat[i*LANE_W +: LANE_W] = merged[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q       <= '0;
      id_q        <= DB_LOW;
      page_q      <= '0;
      commit_v    <= 1'b0;
      commit_id   <= DB_LOW;
      commit_page <= '0;
      commit_data <= '0;
      for (int i = 0; i < LANES; i++) dw_q[i] <= '0;
    end else begin
      commit_v <= fire_top;
      if (fire_top) begin
        commit_data <= merged_flat;
        commit_page <= wr_page;
        commit_id   <= wr_id;
        vld_q       <= '0;
      end else if (gather) begin
        for (int i = 0; i < LANES; i++) dw_q[i] <= merged[i];
        vld_q  <= keep | wr_mask;
        id_q   <= wr_id;
        page_q <= wr_page;
      end else if (inval) begin
        vld_q <= '0;
      end
    end
  end

  assign held_vld = vld_q;

  p_empty_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_v |-> (vld_q == '0));
endmodule

// File: rtl/dbc_plain_reg.sv
module dbc_plain_reg #(
  parameter int PG_W     = 11,
  parameter int PG_SHIFT = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [PG_W-1:0]     page,
  input  logic [PG_SHIFT-1:0] off,
  input  logic [31:0]         data,
  output logic                out_v,
  output logic [PG_W-1:0]     out_page,
  output logic [PG_SHIFT-1:0] out_off,
  output logic [31:0]         out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_page <= '0;
      out_off  <= '0;
      out_data <= '0;
    end else begin
      out_v <= hit;
      if (hit) begin
        out_page <= page;
        out_off  <= off;
        out_data <= data;
      end
    end
  end
endmodule

// File: rtl/wide_doorbell_collector.sv
module wide_doorbell_collector
  import dbc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter bit BIG_PAGES = 1'b0,
  parameter logic [31:0] DB0_OFF = 32'h0830,
  parameter logic [31:0] DB1_OFF = 32'h0a10,
  parameter logic [31:0] TMR_OFF = 32'h0420,
  localparam int PG_SHIFT = BIG_PAGES ? 16 : 13,
  localparam int PG_W     = ADDR_W - PG_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_dw64,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [63:0]         wr_data,
  output logic                commit_valid,
  output logic                commit_reg,
  output logic [PG_W-1:0]     commit_page,
  output logic [WIDE_W-1:0]   commit_data,
  output logic                plain_valid,
  output logic [PG_W-1:0]     plain_page,
  output logic [PG_SHIFT-1:0] plain_offset,
  output logic [31:0]         plain_data,
  output logic                err_o
);
  logic [PG_W-1:0]     dec_page;
  logic [PG_SHIFT-1:0] dec_off;
  logic                dec_wide, dec_plain, dec_inval, dec_bad;
  db_id_e              dec_id, c_id;
  logic [LANES-1:0]    dec_mask;
  logic [LANES-1:0]    held_vld;

  dbc_decode #(
    .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .PG_W(PG_W),
    .DB0_OFF(DB0_OFF), .DB1_OFF(DB1_OFF), .TMR_OFF(TMR_OFF)
  ) u_dec (
    .fire(wr_en), .dw64(wr_dw64), .addr(wr_addr),
    .page(dec_page), .off(dec_off), .hit_wide(dec_wide), .wide_id(dec_id),
    .lane_mask(dec_mask), .hit_plain(dec_plain), .hit_inval(dec_inval), .hit_bad(dec_bad)
  );

  dbc_collector #(.PG_W(PG_W)) u_col (
    .clk(clk), .rst_n(rst_n), .wr_hit(dec_wide), .wr_dw64(wr_dw64), .wr_id(dec_id),
    .wr_page(dec_page), .wr_mask(dec_mask), .wr_data(wr_data), .inval(dec_inval),
    .commit_v(commit_valid), .commit_id(c_id), .commit_page(commit_page),
    .commit_data(commit_data), .held_vld(held_vld)
  );

  assign commit_reg = c_id;

  dbc_plain_reg #(.PG_W(PG_W), .PG_SHIFT(PG_SHIFT)) u_plain (
    .clk(clk), .rst_n(rst_n), .hit(dec_plain), .page(dec_page), .off(dec_off),
    .data(wr_data[31:0]), .out_v(plain_valid), .out_page(plain_page),
    .out_off(plain_offset), .out_data(plain_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= dec_bad;
  end

  p_commit_from_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_en && wr_addr[3] && (wr_dw64 || wr_addr[2])));

  p_err_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!commit_valid && !plain_valid));

  p_plain_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_plain && !dec_inval) |=> $stable(held_vld));

  p_inval_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_inval |=> (held_vld == '0));

  p_bad_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |=> $stable(held_vld));
endmodule

// File: tb/tb_wide_doorbell_collector.sv
`timescale 1ns/1ps
module tb_wide_doorbell_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_dw64 = 1'b0;
  logic [23:0]  wr_addr = '0;
  logic [63:0]  wr_data = '0;

  logic         cv, creg, pv, err;
  logic [10:0]  cpage, ppage;
  logic [127:0] cdata;
  logic [12:0]  poff;
  logic [31:0]  pdata;

  logic         cv_b, creg_b, pv_b, err_b;
  logic [7:0]   cpage_b, ppage_b;
  logic [127:0] cdata_b;
  logic [15:0]  poff_b;
  logic [31:0]  pdata_b;

  int nchk = 0, nbad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wide_doorbell_collector #(.ADDR_W(24), .BIG_PAGES(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw64(wr_dw64), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_valid(cv), .commit_reg(creg), .commit_page(cpage),
    .commit_data(cdata), .plain_valid(pv), .plain_page(ppage), .plain_offset(poff),
    .plain_data(pdata), .err_o(err));

  wide_doorbell_collector #(.ADDR_W(24), .BIG_PAGES(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw64(wr_dw64), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_valid(cv_b), .commit_reg(creg_b), .commit_page(cpage_b),
    .commit_data(cdata_b), .plain_valid(pv_b), .plain_page(ppage_b), .plain_offset(poff_b),
    .plain_data(pdata_b), .err_o(err_b));

  typedef struct packed {
    logic         d64;
    logic [23:0]  a;
    logic [63:0]  d;
    logic         ec;
    logic         er;
    logic [10:0]  ep;
    logic [127:0] ed;
    logic         epl;
    logic         eer;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h002830, 64'h11111111, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b0, 24'h002834, 64'h22222222, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b0, 24'h002838, 64'h33333333, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b0, 24'h00283c, 64'h44444444, 1'b1, 1'b0, 11'd1,
      128'h44444444_33333333_22222222_11111111, 1'b0, 1'b0},
    '{1'b1, 24'h004a10, 64'hBBBBBBBB_AAAAAAAA, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b1, 24'h004a18, 64'hDDDDDDDD_CCCCCCCC, 1'b1, 1'b1, 11'd2,
      128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA, 1'b0, 1'b0},
    '{1'b0, 24'h000a1c, 64'h55555555, 1'b1, 1'b1, 11'd0,
      128'h55555555_00000000_00000000_00000000, 1'b0, 1'b0},
    '{1'b0, 24'h000830, 64'h66666666, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b0, 24'h000838, 64'h77777777, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b0},
    '{1'b0, 24'h00083c, 64'h88888888, 1'b1, 1'b0, 11'd0,
      128'h88888888_77777777_00000000_66666666, 1'b0, 1'b0},
    '{1'b0, 24'h000400, 64'h12345678, 1'b0, 1'b0, 11'd0, 128'h0, 1'b1, 1'b0},
    '{1'b0, 24'h002832, 64'h99999999, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b1},
    '{1'b1, 24'h000834, 64'h9999999999999999, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b1},
    '{1'b1, 24'h000400, 64'h9999999999999999, 1'b0, 1'b0, 11'd0, 128'h0, 1'b0, 1'b1}
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R2", "R2", "R3", "R3", "R4",
                                   "R5", "R5", "R5", "R10", "R11", "R11", "R11"};

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic d64, input logic [23:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_dw64 = d64; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_dw64 = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic expect_commit(input string tag, input logic r, input logic [10:0] p,
                               input logic [127:0] d);
    chk({tag, " commit_valid"}, 128'(cv), 128'd1);
    chk({tag, " commit_reg"}, 128'(creg), 128'(r));
    chk({tag, " commit_page"}, 128'(cpage), 128'(p));
    chk({tag, " commit_data"}, cdata, d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset and right after it
    chk("R1 commit idle", 128'(cv), 128'd0);
    chk("R1 plain idle", 128'(pv), 128'd0);
    chk("R1 err idle", 128'(err), 128'd0);
    rst_n = 1'b1;
    do_wr(1'b0, 24'h00083c, 64'hF00D);
    expect_commit("R1", 1'b0, 11'd0, 128'h0000F00D_00000000_00000000_00000000);

    // vector table
    for (int k = 0; k < NV; k++) begin
      do_wr(VECS[k].d64, VECS[k].a, VECS[k].d);
      chk({TAGS[k], " commit_valid"}, 128'(cv), 128'(VECS[k].ec));
      if (VECS[k].ec) begin
        chk({TAGS[k], " commit_reg"}, 128'(creg), 128'(VECS[k].er));
        chk({TAGS[k], " commit_page"}, 128'(cpage), 128'(VECS[k].ep));
        chk({TAGS[k], " commit_data"}, cdata, VECS[k].ed);
      end
      chk({TAGS[k], " plain_valid"}, 128'(pv), 128'(VECS[k].epl));
      if (VECS[k].epl) begin
        chk({TAGS[k], " plain_page"}, 128'(ppage), 128'(VECS[k].a[23:13]));
        chk({TAGS[k], " plain_offset"}, 128'(poff), 128'(VECS[k].a[12:0]));
        chk({TAGS[k], " plain_data"}, 128'(pdata), 128'(VECS[k].d[31:0]));
      end
      chk({TAGS[k], " err"}, 128'(err), 128'(VECS[k].eer));
    end

    // R6: single-cycle pulse, collector empty afterwards
    do_wr(1'b0, 24'h000830, 64'h10);
    do_wr(1'b0, 24'h00083c, 64'h11);
    expect_commit("R6", 1'b0, 11'd0, 128'h00000011_00000000_00000000_00000010);
    @(negedge clk);
    chk("R6 pulse ends", 128'(cv), 128'd0);
    do_wr(1'b0, 24'h00083c, 64'h12);
    expect_commit("R6 emptied", 1'b0, 11'd0, 128'h00000012_00000000_00000000_00000000);

    // R8 and R12: timer write in page 0 clears, in page 1 does not
    do_wr(1'b0, 24'h000830, 64'hAAAA0001);
    do_wr(1'b0, 24'h000420, 64'h7);
    chk("R12 timer plain p0", 128'(pv), 128'd1);
    chk("R12 timer offset", 128'(poff), 128'h420);
    do_wr(1'b0, 24'h00083c, 64'hBEEF);
    expect_commit("R8 page0", 1'b0, 11'd0, 128'h0000BEEF_00000000_00000000_00000000);
    do_wr(1'b0, 24'h002830, 64'h1234);
    do_wr(1'b0, 24'h002420, 64'h7);
    chk("R12 timer plain p1", 128'(pv), 128'd1);
    chk("R12 timer page", 128'(ppage), 128'd1);
    do_wr(1'b0, 24'h00283c, 64'h99);
    expect_commit("R8 page1", 1'b0, 11'd1, 128'h00000099_00000000_00000000_00001234);

    // R9: switching page or doorbell discards earlier lanes
    do_wr(1'b0, 24'h000830, 64'h5);
    do_wr(1'b0, 24'h002834, 64'h6);
    do_wr(1'b0, 24'h00283c, 64'h7);
    expect_commit("R9 page", 1'b0, 11'd1, 128'h00000007_00000000_00000006_00000000);
    do_wr(1'b0, 24'h000a10, 64'h8);
    do_wr(1'b0, 24'h00083c, 64'h9);
    expect_commit("R9 reg", 1'b0, 11'd0, 128'h00000009_00000000_00000000_00000000);

    // R10: plain write leaves the collector alone
    do_wr(1'b0, 24'h000830, 64'hC0);
    do_wr(1'b0, 24'h000400, 64'h1);
    do_wr(1'b0, 24'h00083c, 64'hC3);
    expect_commit("R10 keep", 1'b0, 11'd0, 128'h000000C3_00000000_00000000_000000C0);

    // R11: misaligned qword ignored, error is a single cycle
    do_wr(1'b0, 24'h000830, 64'hE0);
    do_wr(1'b1, 24'h000834, 64'hFFFFFFFF_FFFFFFFF);
    chk("R11 err", 128'(err), 128'd1);
    chk("R11 no commit", 128'(cv), 128'd0);
    @(negedge clk);
    chk("R11 err one cycle", 128'(err), 128'd0);
    do_wr(1'b0, 24'h00083c, 64'hE3);
    expect_commit("R11 ignored", 1'b0, 11'd0, 128'h000000E3_00000000_00000000_000000E0);

    // R7: page split for both page sizes
    do_wr(1'b0, 24'h010830, 64'hD0);
    do_wr(1'b0, 24'h01083c, 64'hD3);
    expect_commit("R7 small pages", 1'b0, 11'd8, 128'h000000D3_00000000_00000000_000000D0);
    chk("R7 big pages valid", 128'(cv_b), 128'd1);
    chk("R7 big pages page", 128'(cpage_b), 128'd1);
    chk("R7 big pages data", cdata_b, 128'h000000D3_00000000_00000000_000000D0);

    @(negedge clk);
    finish_run();
  end
endmodule